// File: doc/BRIEF.md
# Interrupt Aggregator with Visible-Masked Mode

This block gathers interrupt events for one port of a four-channel line interface. Event pulses land in eight status registers of eight bits each. Every status register has its own mask register. A ninth one-bit status register holds the lock-change event of the shared PLL, which has its own mask bit. The block builds three outputs from the unmasked active bits: a global status word with one bit per status register, a per-channel summary word, and one level interrupt pin.

A visibility mode input changes how masked events are handled. With the mode off, a masked event is dropped. With the mode on, a masked event is still latched, so software can poll for it. Such a bit never drives the pin and never appears in the global word. The PLL register has a separate visibility input that works the same way. Software reads through a simple register read port. Reading a status register returns its contents and clears it. Mask registers are written through a plain write port.

The read port has no back-pressure. It accepts a request in every cycle and answers exactly one cycle later with `rd_valid_o`. The write port also takes one write per cycle.

Top module: `irq_aggregator`

## Requirements
- R1: With `vis_mode_i` at 0, an event on a bit whose mask bit is 1 is not latched, and a later read of that status register returns 0 in that bit.
- R2: With `vis_mode_i` at 1, an event on a masked bit is latched into its status register. An event on an unmasked bit is latched whatever the mode.
- R3: Bit r of `gis_o` (also readable at address 9) is 1 exactly when status register r holds at least one bit that is 1 and whose mask bit is 0. Masked-but-visible bits never set it.
- R4: `irq_o` is active high and level type. It is 1 exactly when some status bit is set with its mask bit 0, in the eight registers or in the PLL register. Masked-but-visible bits never raise it.
- R5: A read with `rd_en_i` at 1 and address 0 to 7 (status register) or 8 (PLL status in bit 0) returns the contents in the next cycle, with `rd_valid_o` at 1. All bits of that register are then cleared, masked-visible ones included.
- R6: Bit c of `chan_o` (also readable at address 10) is the OR of `gis_o` bits c and c+4. So channel c owns status registers c and c+4.
- R7: The PLL mask is bit 0 of write address 8. With the mask at 1, a PLL event is latched only when `pll_vis_i` is 1, and it never raises `irq_o`. With the mask at 0, it raises `irq_o`. PLL status never appears in `gis_o`.
- R8: An unmasked event that arrives in the same cycle as the read of its register is still latched after the clear.
- R9: `irq_o` falls in the cycle after the read that clears the last unmasked active bit.
- R10: After synchronous reset, all status bits are 0 and all mask bits are 1, so `irq_o`, `gis_o` and `chan_o` are 0.
- R11: Writing a mask bit from 1 to 0 while its masked-visible status bit is set raises `gis_o` and `irq_o` in the following cycle.
- R12: Reads at addresses 9 and 10 do not change any state, and repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| isr_evt_i | input | 64 | Event pulses; bits 8r+7..8r belong to status register r |
| pll_evt_i | input | 1 | PLL lock-change event pulse |
| vis_mode_i | input | 1 | Latch masked events of the eight status registers |
| pll_vis_i | input | 1 | Latch a masked PLL event |
| wr_en_i | input | 1 | Mask write strobe |
| wr_addr_i | input | 4 | Mask address: 0 to 7 status masks, 8 PLL mask |
| wr_data_i | input | 8 | Mask write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 4 | Read address: 0 to 7 status, 8 PLL, 9 global, 10 channel |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 8 | Read data |
| gis_o | output | 8 | Global status word |
| chan_o | output | 4 | Channel summary word |
| irq_o | output | 1 | Interrupt pin, active high level |

## Verification
The first pattern fires all 64 event bits at once with every mask set and the mode off. This separates dropping a masked event from latching it. The next pattern uses a mixed mask, with some bits masked and some not, in registers that belong to two channels. It tells apart the latched bits, the global bits and the channel bits. The visible-mode patterns latch events behind full masks, then unmask one bit. These check that the pin and global word stay low until the promotion. The final patterns place an event in the same cycle as its clearing read, and drive PLL events under each combination of the PLL mask and its visibility input.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SREG = 8;
  localparam int ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] ADDR_PLL  = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_GIS  = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_CHAN = 4'd10;

  typedef enum logic [2:0] {
    SEL_STAT, SEL_PLL, SEL_GIS, SEL_CHAN, SEL_NONE
  } rd_sel_e;

  function automatic rd_sel_e decode_rd(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(NUM_SREG)) return SEL_STAT;
    else if (a == ADDR_PLL)    return SEL_PLL;
    else if (a == ADDR_GIS)    return SEL_GIS;
    else if (a == ADDR_CHAN)   return SEL_CHAN;
    else                       return SEL_NONE;
  endfunction
endpackage

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vis_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] take;

  // unmasked events always enter; masked ones only in visible mode
  always_comb take = evt_i & (~mask_i | {W{vis_i}});

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (clr_i ? '0 : stat_q) | take;
  end

  assign stat_o = stat_q;

  AST_MASKED_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (!vis_i && !clr_i && ((evt_i & mask_i & ~stat_q) != '0))
    |=> ((stat_q & $past(evt_i & mask_i & ~stat_q)) == '0)); // R1
  AST_VISIBLE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (vis_i && (evt_i != '0)) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (evt_i == '0)) |=> (stat_q == '0)); // R5
  AST_EVT_OVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && ((evt_i & ~mask_i) != '0))
    |=> ((stat_q & $past(evt_i & ~mask_i)) == $past(evt_i & ~mask_i))); // R8
endmodule

// File: rtl/irq_mask_file.sv
module irq_mask_file
  import irq_agg_pkg::*;
#(
  parameter int N = NUM_SREG,
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [W-1:0]        data_i,
  output logic [N-1:0][W-1:0] mask_o,
  output logic                pll_mask_o
);
  logic [N-1:0][W-1:0] mask_q;
  logic                pll_mask_q;

  for (genvar r = 0; r < N; r++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)                                       mask_q[r] <= '1;
      else if (we_i && (addr_i == ADDR_W'(r)))       mask_q[r] <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                pll_mask_q <= 1'b1;
    else if (we_i && (addr_i == ADDR_PLL))  pll_mask_q <= data_i[0];
  end

  assign mask_o     = mask_q;
  assign pll_mask_o = pll_mask_q;

  AST_MASKS_SET_BY_RESET: assert property (@(posedge clk)
    rst |=> ((mask_q == '1) && pll_mask_q)); // R10
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int N   = 8,
  parameter int W   = 8,
  parameter int NCH = 4
) (
  input  logic [N-1:0][W-1:0] stat_i,
  input  logic [N-1:0][W-1:0] mask_i,
  input  logic                pll_stat_i,
  input  logic                pll_mask_i,
  output logic [N-1:0]        gis_o,
  output logic [NCH-1:0]      chan_o,
  output logic                irq_o
);
  for (genvar r = 0; r < N; r++) begin : g_gis
    assign gis_o[r] = |(stat_i[r] & ~mask_i[r]);
  end

  always_comb begin
    chan_o = '0;
    for (int r = 0; r < N; r++) begin
      chan_o[r % NCH] = chan_o[r % NCH] | gis_o[r];
    end
  end

  assign irq_o = (|gis_o) | (pll_stat_i & ~pll_mask_i);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SREG*REG_W-1:0] isr_evt_i,
  input  logic                      pll_evt_i,
  input  logic                      vis_mode_i,
  input  logic                      pll_vis_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic                      rd_valid_o,
  output logic [REG_W-1:0]          rd_data_o,
  output logic [NUM_SREG-1:0]       gis_o,
  output logic [NUM_CH-1:0]         chan_o,
  output logic                      irq_o
);
  localparam int N = NUM_SREG;

  logic [N-1:0][REG_W-1:0] stat, mask;
  logic                    pll_stat, pll_mask;
  logic [N-1:0]            clr;
  logic                    pll_clr;
  rd_sel_e                 sel;
  logic [REG_W-1:0]        rd_d, rd_q;
  logic                    rd_v_q;

  assign sel     = decode_rd(rd_addr_i);
  assign pll_clr = rd_en_i && (sel == SEL_PLL);

  irq_mask_file #(.N(N), .W(REG_W)) u_masks (
    .clk, .rst, .we_i(wr_en_i), .addr_i(wr_addr_i), .data_i(wr_data_i),
    .mask_o(mask), .pll_mask_o(pll_mask)
  );

  for (genvar r = 0; r < N; r++) begin : g_stat
    assign clr[r] = rd_en_i && (sel == SEL_STAT) && (rd_addr_i == ADDR_W'(r));
    irq_stat_reg #(.W(REG_W)) u_stat (
      .clk, .rst, .vis_i(vis_mode_i), .mask_i(mask[r]),
      .evt_i(isr_evt_i[r*REG_W +: REG_W]), .clr_i(clr[r]), .stat_o(stat[r])
    );
  end

  irq_stat_reg #(.W(1)) u_pll (
    .clk, .rst, .vis_i(pll_vis_i), .mask_i(pll_mask),
    .evt_i(pll_evt_i), .clr_i(pll_clr), .stat_o(pll_stat)
  );

  irq_summary #(.N(N), .W(REG_W), .NCH(NUM_CH)) u_sum (
    .stat_i(stat), .mask_i(mask), .pll_stat_i(pll_stat), .pll_mask_i(pll_mask),
    .gis_o, .chan_o, .irq_o
  );

  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_STAT: rd_d = stat[rd_addr_i[$clog2(N)-1:0]];
      SEL_PLL:  rd_d = REG_W'(pll_stat);
      SEL_GIS:  rd_d = REG_W'(gis_o);
      SEL_CHAN: rd_d = REG_W'(chan_o);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      rd_v_q <= 1'b0;
    end else begin
      rd_q   <= rd_en_i ? rd_d : rd_q;
      rd_v_q <= rd_en_i;
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = rd_v_q;

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o); // R5
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((gis_o != '0) || (pll_stat && !pll_mask))); // R4
  AST_CHAN_TRACKS_GIS: assert property (@(posedge clk) disable iff (rst)
    ((chan_o != '0) == (gis_o != '0))); // R6
  AST_PLL_NOT_IN_GIS: assert property (@(posedge clk) disable iff (rst)
    (pll_stat && !pll_mask && (gis_o == '0)) |-> irq_o); // R7
endmodule

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] isr_evt = '0;
  logic        pll_evt = 1'b0, vis_mode = 1'b0, pll_vis = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_valid, irq;
  logic [7:0]  rd_data, gis;
  logic [3:0]  chan;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] m_st [8];
  logic [7:0] m_mk [8];
  logic       m_pst, m_pmk;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst(rst), .isr_evt_i(isr_evt), .pll_evt_i(pll_evt),
    .vis_mode_i(vis_mode), .pll_vis_i(pll_vis), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .gis_o(gis), .chan_o(chan), .irq_o(irq)
  );

  function automatic logic [7:0] e_gis();
    logic [7:0] g;
    for (int r = 0; r < 8; r++) g[r] = |(m_st[r] & ~m_mk[r]);
    return g;
  endfunction
  function automatic logic [3:0] e_chan();
    logic [7:0] g = e_gis();
    return g[3:0] | g[7:4];
  endfunction
  function automatic logic e_irq();
    return (e_gis() != 0) || (m_pst && !m_pmk);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " gis"}, gis, e_gis());
    chk({tag, " chan"}, {4'h0, chan}, {4'h0, e_chan()});
    chk({tag, " irq"}, {7'h0, irq}, {7'h0, e_irq()});
  endtask

  task automatic model_evt(input logic [63:0] ev, input logic pev);
    for (int r = 0; r < 8; r++)
      m_st[r] |= ev[r*8 +: 8] & (~m_mk[r] | {8{vis_mode}});
    m_pst |= pev & (!m_pmk | pll_vis);
  endtask

  task automatic fire(input logic [63:0] ev, input logic pev);
    isr_evt = ev; pll_evt = pev;
    model_evt(ev, pev);
    @(negedge clk);
    isr_evt = '0; pll_evt = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a < 8) m_mk[a] = d; else if (a == 8) m_pmk = d[0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected answer, then updates the model
  task automatic rd(input logic [3:0] a, input string tag, input logic [63:0] ev = '0);
    logic [7:0] e;
    if (a < 8)        e = m_st[a];
    else if (a == 8)  e = {7'h0, m_pst};
    else if (a == 9)  e = e_gis();
    else if (a == 10) e = {4'h0, e_chan()};
    else              e = '0;
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a; isr_evt = ev;
    if (a < 8) m_st[a] = '0; else if (a == 8) m_pst = 1'b0;
    model_evt(ev, 1'b0);
    @(negedge clk);
    rd_en = 1'b0; isr_evt = '0;
  endtask

  // monitor: compares each answer as it appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: unexpected rd_valid, actual %h expected none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5: %0d reads unanswered, actual 0 expected %0d", exp_q.size(), exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) begin m_st[r] = '0; m_mk[r] = '1; end
    m_pst = 1'b0; m_pmk = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_outs("R10 reset");

    // R1 / R10: all masks set after reset, mode off -> everything dropped
    fire('1, 1'b1);
    chk_outs("R1 masked dropped");
    rd(4'd3, "R1 reg3 empty");
    rd(4'd8, "R7 pll masked dropped");

    // R3 / R6 / R4: mixed masks in two channels
    wr(4'd0, 8'h00);
    wr(4'd5, 8'hF0);
    fire({16'h0, 8'h3C, 32'h0, 8'h81}, 1'b0);
    chk_outs("R3 R6 R4 mixed");
    rd(4'd9, "R3 gis read");
    rd(4'd10, "R6 chan read");
    rd(4'd9, "R12 gis reread");
    rd(4'd10, "R12 chan reread");
    chk_outs("R12 no side effect");

    // R5 / R9: clearing reads; pin falls after the last one
    rd(4'd0, "R5 reg0 read");
    chk_outs("R9 after first clear");
    rd(4'd5, "R5 reg5 read");
    chk_outs("R9 irq dropped");
    rd(4'd5, "R5 reg5 cleared");

    // R2 / R11: visible mode
    vis_mode = 1'b1;
    fire({40'h0, 8'h55, 16'h0}, 1'b0);
    chk_outs("R2 visible no irq");
    wr(4'd2, 8'hFE);
    chk_outs("R11 promoted");
    rd(4'd2, "R5 masked and unmasked cleared");
    chk_outs("R9 cleared after promote");
    rd(4'd2, "R5 reg2 empty");
    vis_mode = 1'b0;

    // R8: event during clearing read
    fire({56'h0, 8'h01}, 1'b0);
    rd(4'd0, "R8 read old", {56'h0, 8'h02});
    chk_outs("R8 event survives");
    rd(4'd0, "R8 survivor read");
    chk_outs("R8 cleared");

    // R7: PLL mask and visibility
    pll_vis = 1'b1;
    fire('0, 1'b1);
    chk_outs("R7 pll visible no irq");
    rd(4'd8, "R7 pll visible latched");
    pll_vis = 1'b0;
    wr(4'd8, 8'h00);
    fire('0, 1'b1);
    chk_outs("R7 pll unmasked irq");
    rd(4'd8, "R7 pll read");
    chk_outs("R7 pll cleared");
    rd(4'd14, "R12 unused address");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule